// File: doc/BRIEF.md
# Windowed Integer Register File

This block holds the integer registers of a processor core that uses overlapping register windows. Software always addresses 32 logical registers through a 5-bit number. A current window pointer picks which physical registers stand behind the windowed part of that space. Eight global registers sit outside the windows and are seen from every window. Each window owns eight private locals. Its eight ins are physically the same storage as the outs of the neighbouring window, so a caller's argument registers become the callee's incoming registers as soon as a save request moves the pointer. No data is copied.

A save request moves the pointer down by one and a restore request moves it up by one, both modulo the window count. An invalid mask with one bit per window guards these moves. When a move would land on a window whose mask bit is set, the pointer stays where it is and an overflow or underflow trap pulse is raised. A control port can load the pointer and the mask directly, for example from trap software that has spilled or filled a window.

There are two combinational read ports and one write port. The write port takes effect on the rising clock edge.

Top module: `rwin_regfile`

## Requirements
- R1: Logical registers 1 to 7 are globals. A value written to one of them reads back unchanged from every window.
- R2: Logical register 0 reads as zero on both read ports, and a write to it changes nothing.
- R3: Logical registers 16 to 23 are the locals of the current window. A value written there while the pointer is W can be read back only while the pointer is W.
- R4: Logical registers 8 to 15 (outs) of window W are the same storage as logical registers 24 to 31 (ins) of window (W-1) mod NWINDOWS.
- R5: With `win_op` = 2'b01 (save) the pointer becomes (cwp-1) mod NWINDOWS after the edge. With 2'b10 (restore) it becomes (cwp+1) mod NWINDOWS. Codes 2'b00 and 2'b11 leave it unchanged.
- R6: A save whose target window has its `wim` bit at 1 leaves `cwp` unchanged and drives `ovf_trap` high for exactly the one cycle after the request.
- R7: A restore whose target window has its `wim` bit at 1 leaves `cwp` unchanged and drives `unf_trap` high for exactly the one cycle after the request. The two trap outputs are never high together.
- R8: A register write presented in the same cycle as a save or restore that traps is discarded.
- R9: A read of the register being written in the same cycle returns the old value. The new value is readable from the next cycle on.
- R10: After reset `cwp` is 0, `wim` is 2 (only bit 1 set), both trap outputs are low and every register reads zero.
- R11: When `cwp_load` or `wim_load` is high, the corresponding value is loaded at the edge. The save or restore of that same cycle is then ignored: it causes no move and no trap.
- R12: A write presented together with a save or restore that does not trap is translated with the pointer value from before the move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 5 | Logical register number, read port A |
| rd_a_data | output | XLEN | Read data, port A (combinational) |
| rd_b_idx | input | 5 | Logical register number, read port B |
| rd_b_data | output | XLEN | Read data, port B (combinational) |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Logical register number for the write |
| wr_data | input | XLEN | Write data |
| win_op | input | 2 | 01 save, 10 restore, 00 and 11 no move |
| cwp_load | input | 1 | Load the window pointer from `cwp_val` |
| cwp_val | input | log2(NWINDOWS) | New window pointer value |
| wim_load | input | 1 | Load the invalid mask from `wim_val` |
| wim_val | input | NWINDOWS | New invalid mask value |
| cwp | output | log2(NWINDOWS) | Current window pointer |
| wim | output | NWINDOWS | Current window invalid mask |
| ovf_trap | output | 1 | Window overflow pulse |
| unf_trap | output | 1 | Window underflow pulse |

## Verification
The bench builds the block with NWINDOWS = 8 and XLEN = 32, which gives a 136-entry physical array and a 3-bit pointer. With eight windows, repeated saves wrap the pointer from 0 to 7 and restores wrap it back. This reaches the aliasing across that wrap, where the outs of window 0 are the ins of window 7. It also reaches the trap against the reset mask from both directions: a restore straight after reset and a chain of six saves. Long random runs with occasional control loads mix writes with moves and traps in the same cycle, and all of them are compared against a behavioural model that keeps separate arrays for globals, locals and ins.

// File: rtl/rwin_pkg.sv
package rwin_pkg;

    localparam int GLOBAL_COUNT = 8;
    localparam int BANK_SIZE    = 8;
    localparam int LOG_IDX_W    = 5;

    typedef enum logic [1:0] {
        WOP_NONE    = 2'b00,
        WOP_SAVE    = 2'b01,
        WOP_RESTORE = 2'b10,
        WOP_IDLE    = 2'b11
    } win_op_e;

    typedef enum logic [1:0] {
        CLS_GLOBAL = 2'b00,
        CLS_OUT    = 2'b01,
        CLS_LOCAL  = 2'b10,
        CLS_IN     = 2'b11
    } reg_class_e;

    typedef struct packed {
        logic ovf;
        logic unf;
    } trap_t;

    function automatic reg_class_e reg_class(input logic [LOG_IDX_W-1:0] idx);
        return reg_class_e'(idx[4:3]);
    endfunction

endpackage

// File: rtl/rwin_xlate.sv
module rwin_xlate
    import rwin_pkg::*;
#(
    parameter int CW = 3,
    parameter int PW = 8
) (
    input  logic [LOG_IDX_W-1:0] log_idx,
    input  logic [CW-1:0]        cur_wp,
    output logic [PW-1:0]        phys_idx
);

    logic [CW-1:0] owner;
    logic          upper_half;
    logic          is_global;

    // Each window owns 16 physical slots: locals in the low half, ins in the
    // high half. Outs borrow the high half of the window one below.
    always_comb begin
        owner      = cur_wp;
        upper_half = 1'b0;
        is_global  = 1'b0;
        unique case (reg_class(log_idx))
            CLS_GLOBAL: is_global = 1'b1;
            CLS_OUT: begin
                owner      = cur_wp - 1'b1;
                upper_half = 1'b1;
            end
            CLS_LOCAL: upper_half = 1'b0;
            CLS_IN:    upper_half = 1'b1;
        endcase
        if (is_global)
            phys_idx = PW'(log_idx[2:0]);
        else
            phys_idx = PW'(GLOBAL_COUNT) + PW'({owner, upper_half, log_idx[2:0]});
    end

endmodule

// File: rtl/rwin_ctrl.sv
module rwin_ctrl
    import rwin_pkg::*;
#(
    parameter int NWINDOWS = 8,
    parameter int CW       = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  win_op_e             op,
    input  logic                cwp_load,
    input  logic [CW-1:0]       cwp_val,
    input  logic                wim_load,
    input  logic [NWINDOWS-1:0] wim_val,
    output logic [CW-1:0]       cwp_q,
    output logic [NWINDOWS-1:0] wim_q,
    output trap_t               trap_q,
    output logic                wr_block
);

    logic [CW-1:0] wp_down;
    logic [CW-1:0] wp_up;
    logic          ctl_any;
    logic          save_req;
    logic          rest_req;
    trap_t         trap_d;

    always_comb begin
        wp_down    = cwp_q - 1'b1;
        wp_up      = cwp_q + 1'b1;
        ctl_any    = cwp_load | wim_load;
        save_req   = !ctl_any && (op == WOP_SAVE);
        rest_req   = !ctl_any && (op == WOP_RESTORE);
        trap_d.ovf = save_req && wim_q[wp_down];
        trap_d.unf = rest_req && wim_q[wp_up];
        wr_block   = trap_d.ovf | trap_d.unf;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cwp_q  <= '0;
            wim_q  <= NWINDOWS'(2);
            trap_q <= '0;
        end else begin
            trap_q <= trap_d;
            if (wim_load)
                wim_q <= wim_val;
            if (cwp_load)
                cwp_q <= cwp_val;
            else if (save_req && !trap_d.ovf)
                cwp_q <= wp_down;
            else if (rest_req && !trap_d.unf)
                cwp_q <= wp_up;
        end
    end

    assert_save_moves_R5: assert property (@(posedge clk) disable iff (rst)
        (op == WOP_SAVE && !cwp_load && !wim_load && !wim_q[wp_down])
        |=> (cwp_q == CW'($past(cwp_q) - 1'b1)));

    assert_restore_moves_R5: assert property (@(posedge clk) disable iff (rst)
        (op == WOP_RESTORE && !cwp_load && !wim_load && !wim_q[wp_up])
        |=> (cwp_q == CW'($past(cwp_q) + 1'b1)));

    assert_ovf_holds_cwp_R6: assert property (@(posedge clk) disable iff (rst)
        trap_q.ovf |-> (cwp_q == $past(cwp_q)));

    assert_unf_holds_cwp_R7: assert property (@(posedge clk) disable iff (rst)
        trap_q.unf |-> (cwp_q == $past(cwp_q)));

    assert_traps_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({trap_q.ovf, trap_q.unf}));

    assert_cwp_load_wins_R11: assert property (@(posedge clk) disable iff (rst)
        cwp_load |=> (cwp_q == $past(cwp_val) && !trap_q.ovf && !trap_q.unf));

    assert_wim_only_by_load_R11: assert property (@(posedge clk) disable iff (rst)
        !wim_load |=> $stable(wim_q));

endmodule

// File: rtl/rwin_store.sv
module rwin_store #(
    parameter int XLEN  = 32,
    parameter int DEPTH = 136,
    parameter int PW    = 8,
    parameter int NREAD = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [PW-1:0]   wr_phys,
    input  logic [XLEN-1:0] wr_data,
    input  logic [PW-1:0]   rd_phys [NREAD],
    output logic [XLEN-1:0] rd_data [NREAD]
);

    logic [XLEN-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_phys] <= wr_data;
        end
    end

    for (genvar p = 0; p < NREAD; p++) begin : g_rd
        assign rd_data[p] = mem[rd_phys[p]];
    end

    assert_write_lands_R9: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (mem[$past(wr_phys)] == $past(wr_data)));

endmodule

// File: rtl/rwin_regfile.sv
module rwin_regfile
    import rwin_pkg::*;
#(
    parameter int NWINDOWS = 8,
    parameter int XLEN     = 32,
    localparam int CW      = (NWINDOWS > 1) ? $clog2(NWINDOWS) : 1,
    localparam int DEPTH   = GLOBAL_COUNT + 2 * BANK_SIZE * NWINDOWS,
    localparam int PW      = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [4:0]           rd_a_idx,
    output logic [XLEN-1:0]      rd_a_data,
    input  logic [4:0]           rd_b_idx,
    output logic [XLEN-1:0]      rd_b_data,
    input  logic                 wr_en,
    input  logic [4:0]           wr_idx,
    input  logic [XLEN-1:0]      wr_data,
    input  logic [1:0]           win_op,
    input  logic                 cwp_load,
    input  logic [CW-1:0]        cwp_val,
    input  logic                 wim_load,
    input  logic [NWINDOWS-1:0]  wim_val,
    output logic [CW-1:0]        cwp,
    output logic [NWINDOWS-1:0]  wim,
    output logic                 ovf_trap,
    output logic                 unf_trap
);

    localparam int NREAD = 2;

    trap_t           trap_q;
    logic            wr_block;
    logic            wr_go;
    logic [PW-1:0]   wr_phys;
    logic [4:0]      rd_log  [NREAD];
    logic [PW-1:0]   rd_phys [NREAD];
    logic [XLEN-1:0] rd_raw  [NREAD];

    rwin_ctrl #(.NWINDOWS(NWINDOWS), .CW(CW)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .op       (win_op_e'(win_op)),
        .cwp_load (cwp_load),
        .cwp_val  (cwp_val),
        .wim_load (wim_load),
        .wim_val  (wim_val),
        .cwp_q    (cwp),
        .wim_q    (wim),
        .trap_q   (trap_q),
        .wr_block (wr_block)
    );

    assign ovf_trap = trap_q.ovf;
    assign unf_trap = trap_q.unf;

    assign rd_log[0] = rd_a_idx;
    assign rd_log[1] = rd_b_idx;

    for (genvar p = 0; p < NREAD; p++) begin : g_rx
        rwin_xlate #(.CW(CW), .PW(PW)) u_rx (
            .log_idx  (rd_log[p]),
            .cur_wp   (cwp),
            .phys_idx (rd_phys[p])
        );
    end

    rwin_xlate #(.CW(CW), .PW(PW)) u_wx (
        .log_idx  (wr_idx),
        .cur_wp   (cwp),
        .phys_idx (wr_phys)
    );

    // Register 0 is never written, so its slot stays at its reset value of zero.
    assign wr_go = wr_en && !wr_block && (wr_idx != '0);

    rwin_store #(.XLEN(XLEN), .DEPTH(DEPTH), .PW(PW), .NREAD(NREAD)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_go),
        .wr_phys (wr_phys),
        .wr_data (wr_data),
        .rd_phys (rd_phys),
        .rd_data (rd_raw)
    );

    assign rd_a_data = rd_raw[0];
    assign rd_b_data = rd_raw[1];

    assert_zero_read_a_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_a_idx == '0) |-> (rd_a_data == '0));

    assert_zero_read_b_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_b_idx == '0) |-> (rd_b_data == '0));

    assert_global_stays_R1: assert property (@(posedge clk) disable iff (rst)
        (rd_a_idx == 5'd1 && !(wr_en && wr_idx == 5'd1)) |=>
        (rd_a_idx != 5'd1 || rd_a_data == $past(rd_a_data)));

endmodule

// File: tb/tb_rwin_regfile.sv
module tb_rwin_regfile;

    localparam int CLK_PERIOD = 10;
    localparam int NW = 8;
    localparam int CW = 3;

    logic            clk = 1'b0;
    logic            rst;
    logic [4:0]      rd_a_idx, rd_b_idx, wr_idx;
    logic [31:0]     rd_a_data, rd_b_data, wr_data;
    logic            wr_en, cwp_load, wim_load;
    logic [1:0]      win_op;
    logic [CW-1:0]   cwp_val, cwp;
    logic [NW-1:0]   wim_val, wim;
    logic            ovf_trap, unf_trap;

    rwin_regfile #(.NWINDOWS(NW), .XLEN(32)) dut (
        .clk(clk), .rst(rst),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .win_op(win_op),
        .cwp_load(cwp_load), .cwp_val(cwp_val),
        .wim_load(wim_load), .wim_val(wim_val),
        .cwp(cwp), .wim(wim),
        .ovf_trap(ovf_trap), .unf_trap(unf_trap)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Behavioural model: separate arrays per register kind.
    logic [31:0] m_glob [8];
    logic [31:0] m_loc  [NW][8];
    logic [31:0] m_ins  [NW][8];
    int          m_cwp;
    logic [NW-1:0] m_wim;
    bit          m_ovf, m_unf;

    function automatic logic [31:0] m_read(input int idx, input int w);
        if (idx == 0)       return 32'h0;
        else if (idx < 8)   return m_glob[idx];
        else if (idx < 16)  return m_ins[(w + NW - 1) % NW][idx - 8];
        else if (idx < 24)  return m_loc[w][idx - 16];
        else                return m_ins[w][idx - 24];
    endfunction

    function automatic string rtag(input int idx);
        if (idx == 0)       return "R2";
        else if (idx < 8)   return "R1";
        else if (idx < 16)  return "R4";
        else if (idx < 24)  return "R3";
        else                return "R4";
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic m_reset();
        for (int i = 0; i < 8; i++) m_glob[i] = '0;
        for (int w = 0; w < NW; w++)
            for (int i = 0; i < 8; i++) begin
                m_loc[w][i] = '0;
                m_ins[w][i] = '0;
            end
        m_cwp = 0;
        m_wim = NW'(2);
        m_ovf = 0;
        m_unf = 0;
    endtask

    // Called just after a falling edge: drive, compare, advance the model, wait one cycle.
    task automatic step(input logic [1:0] op, input bit we, input int wi, input logic [31:0] wd,
                        input int ra, input int rb, input bit cwe, input int cv,
                        input bit wwe, input logic [NW-1:0] wv, input string over);
        bit t_o, t_u, ctl;
        int dn, up;
        win_op = op; wr_en = we; wr_idx = 5'(wi); wr_data = wd;
        rd_a_idx = 5'(ra); rd_b_idx = 5'(rb);
        cwp_load = cwe; cwp_val = CW'(cv); wim_load = wwe; wim_val = wv;
        #1;
        chk(rd_a_data == m_read(ra, m_cwp), (over != "") ? over : rtag(ra), "rd_a",
            rd_a_data, m_read(ra, m_cwp));
        chk(rd_b_data == m_read(rb, m_cwp), (over != "") ? over : rtag(rb), "rd_b",
            rd_b_data, m_read(rb, m_cwp));
        chk(int'(cwp) == m_cwp, "R5", "cwp", cwp, m_cwp);
        chk(wim == m_wim, "R11", "wim", wim, m_wim);
        chk(ovf_trap == m_ovf, "R6", "ovf_trap", ovf_trap, m_ovf);
        chk(unf_trap == m_unf, "R7", "unf_trap", unf_trap, m_unf);
        // advance model as on the coming edge
        ctl = cwe | wwe;
        dn = (m_cwp + NW - 1) % NW;
        up = (m_cwp + 1) % NW;
        t_o = !ctl && op == 2'b01 && m_wim[dn];
        t_u = !ctl && op == 2'b10 && m_wim[up];
        if (we && wi != 0 && !(t_o || t_u)) begin
            if (wi < 8)       m_glob[wi] = wd;
            else if (wi < 16) m_ins[dn][wi - 8] = wd;
            else if (wi < 24) m_loc[m_cwp][wi - 16] = wd;
            else              m_ins[m_cwp][wi - 24] = wd;
        end
        if (cwe)                               m_cwp = cv % NW;
        else if (!ctl && op == 2'b01 && !t_o)  m_cwp = dn;
        else if (!ctl && op == 2'b10 && !t_u)  m_cwp = up;
        if (wwe) m_wim = wv;
        m_ovf = t_o;
        m_unf = t_u;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_read(input int ra, input int rb, input string over);
        step(2'b00, 0, 0, 0, ra, rb, 0, 0, 0, '0, over);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1; win_op = 0; wr_en = 0; wr_idx = 0; wr_data = 0;
        rd_a_idx = 0; rd_b_idx = 0; cwp_load = 0; cwp_val = 0; wim_load = 0; wim_val = 0;
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R10: reset state
        #1;
        chk(cwp == 0, "R10", "cwp after reset", cwp, 0);
        chk(wim == NW'(2), "R10", "wim after reset", wim, 2);
        chk(!ovf_trap && !unf_trap, "R10", "traps after reset", {ovf_trap, unf_trap}, 0);
        idle_read(5, 20, "R10");

        // R2: write to register 0 discarded
        step(2'b00, 1, 0, 32'hDEAD_BEEF, 0, 0, 0, 0, 0, '0, "R2");
        idle_read(0, 0, "R2");
        // globals, outs, locals in window 0
        step(2'b00, 1, 3, 32'h1111_0003, 0, 0, 0, 0, 0, '0, "");
        step(2'b00, 1, 8, 32'h0A0A_0008, 3, 0, 0, 0, 0, '0, "R1");
        step(2'b00, 1, 17, 32'h1717_0017, 8, 0, 0, 0, 0, '0, "R4");
        // R9: read during write sees old value, then new value
        step(2'b00, 1, 17, 32'h2222_0017, 17, 17, 0, 0, 0, '0, "R9");
        idle_read(17, 17, "R9");
        // R7: restore right after reset targets window 1 (invalid) -> underflow, write dropped (R8)
        step(2'b10, 1, 17, 32'hBAD0_0017, 17, 0, 0, 0, 0, '0, "R8");
        idle_read(17, 3, "R8");
        // R12: save with write to o1 in same cycle uses old pointer (window 0)
        step(2'b01, 1, 9, 32'h0909_0009, 0, 0, 0, 0, 0, '0, "R12");
        // now cwp 7: ins 24/25 alias window 0 outs (R4), locals private (R3), global visible (R1)
        idle_read(24, 25, "R4");
        idle_read(16, 17, "R3");
        idle_read(3, 0, "R1");
        // save down to window 2, then one more save traps at window 1 (R6)
        for (int k = 0; k < 5; k++) step(2'b01, 0, 0, 0, 24, 3, 0, 0, 0, '0, "");
        step(2'b01, 1, 3, 32'hBAD0_0003, 0, 0, 0, 0, 0, '0, "R6");
        idle_read(3, 24, "R8");
        // R11: control load wins over a save
        step(2'b01, 0, 0, 0, 0, 0, 1, 0, 0, '0, "R11");
        step(2'b10, 0, 0, 0, 16, 17, 0, 0, 1, NW'(8'h10), "R11");
        idle_read(16, 17, "R3");
        // R5: codes 00 and 11 do not move
        step(2'b11, 0, 0, 0, 8, 9, 0, 0, 0, '0, "R5");
        step(2'b10, 0, 0, 0, 8, 9, 0, 0, 0, '0, "R5");

        // random phase
        for (int n = 0; n < 4000; n++) begin
            int r;
            bit cwe, wwe;
            r = $urandom % 100;
            cwe = (r < 3);
            wwe = (r >= 3 && r < 6);
            step(2'($urandom), ($urandom % 10) < 7, int'($urandom % 32), $urandom,
                 int'($urandom % 32), int'($urandom % 32), cwe, int'($urandom % NW),
                 wwe, NW'(1) << ($urandom % NW), "");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule